// File: doc/BRIEF.md
# Triggered Diagnostic Capture Memory

This block records loop signals for later inspection and drives a test waveform into the loop. It watches one stream of samples, each marked by a valid strobe, and keeps two capture buffers. The fault-history ring stores every valid sample and wraps, with no pause. When the fault trigger arrives, the ring stops writing and keeps the address of the slot where the next sample would have gone. That slot holds the oldest sample, so software can read the ring in time order starting there. The snapshot buffer stays idle until an operator trigger arrives. It then stores one sample out of every N, with N chosen in a register, until it is full.

An excitation table can be loaded through the register bus. The analyze trigger starts the snapshot capture and the table playback on the same clock edge. Each time the snapshot buffer stores a sample, the playback moves to the next table entry. Response and stimulus therefore stay aligned sample for sample, which gives a built-in signal analyzer. The three triggers are separate active-low inputs. The block assumes they are already synchronous to `clk`, and it reacts to the high-to-low transition only. A register bus with one cycle of read latency gives access to control, status and both buffers.

Top module: `diag_capture_mem`

## Requirements
- R1: After reset, the status word (register offset 0 of region 0) reads 0x6. Bits [1:0] hold the ring state and bits [3:2] hold the snapshot state, each coded 1 = armed, 2 = capturing, 3 = done. So after reset the ring is capturing and the snapshot is armed. `exc_valid` and `exc_data` are 0.
- R2: While capturing, the ring writes every valid sample to the next slot of a DEPTH-entry memory and wraps after the last slot. Region 1, offset k, reads slot k.
- R3: A falling edge on `pm_trig_n` while the ring is capturing freezes the ring and sets its state to done. It latches the next write slot into register offset 2. No valid sample in that cycle or later is stored.
- R4: A fault trigger that arrives while the ring is done has no effect on the latched address or on the ring contents.
- R5: A register write to offset 0 with bit 0 set returns the ring to capturing, starting at slot 0. A write to offset 0 with bit 1 set returns the snapshot buffer to armed and stops playback.
- R6: While the snapshot buffer is armed it stores nothing. A falling edge on `obs_trig_n` moves it to capturing.
- R7: Register offset 1 holds N-1, a 16-bit value, so N runs from 1 to 65536. The first valid sample after the trigger edge is stored, and after that every N-th valid sample.
- R8: After DEPTH stores the snapshot buffer becomes done. Later samples leave its contents unchanged. Region 2, offset k, reads the k-th stored sample.
- R9: A falling edge on `ana_trig_n` while the snapshot buffer is armed starts the capture and the playback on the same edge. From the clock edge after the trigger, `exc_valid` is 1. After the clock edge of the k-th snapshot store (k counted from 1), `exc_data` holds table entry k-1.
- R10: On the clock edge after the snapshot buffer becomes done, playback stops and both `exc_valid` and `exc_data` go to 0.
- R11: An analyze trigger that arrives while the snapshot buffer is not armed starts no playback and does not change the snapshot state.
- R12: Bits [AW+1:AW] of the bus address select the region: 0 = control, 1 = ring, 2 = snapshot, 3 = excitation table (write only). `bus_rdata` is valid one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Sample value |
| pm_trig_n | input | 1 | Fault trigger, active low |
| obs_trig_n | input | 1 | Snapshot trigger, active low |
| ana_trig_n | input | 1 | Analyze trigger, active low |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | AW+2 | Region select and offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, one cycle after the address |
| exc_data | output | DW | Excitation sample |
| exc_valid | output | 1 | Playback active |

## Verification
A trigger takes effect on the clock edge where the low level is first seen. A status read placed after the trigger pulse therefore shows the new state. Its result is sampled 1 ns after the next edge, because bus reads take one cycle. The excitation output is checked 1 ns after every store edge, against table entry k-1 for the k-th store. One more edge after the last store it is checked for zero. Captured contents are checked only after the capture ends, at addresses worked out from the sample sequence, the latched slot and the divider.

// File: rtl/diag_pkg.sv
`timescale 1ns/1ps
package diag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } cap_st_t;

  localparam logic [1:0] RGN_CTRL = 2'd0;
  localparam logic [1:0] RGN_RING = 2'd1;
  localparam logic [1:0] RGN_SNAP = 2'd2;
  localparam logic [1:0] RGN_EXC  = 2'd3;
endpackage

// File: rtl/dcm_pm_ring.sv
`timescale 1ns/1ps
module dcm_pm_ring
  import diag_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          trig,
  input  logic          rearm,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output cap_st_t       state,
  output logic [AW-1:0] trig_addr
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp;
  logic          we;

  assign we = smp_valid && (state == ST_CAPT) && !trig && !rearm;

  always_ff @(posedge clk) begin
    if (we) mem[wp] <= smp_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CAPT;
      wp        <= '0;
      trig_addr <= '0;
    end else if (rearm) begin
      state <= ST_CAPT;
      wp    <= '0;
    end else begin
      if (state == ST_CAPT && trig) begin
        state     <= ST_DONE;
        trig_addr <= wp;
      end
      if (we) wp <= wp + 1'b1;
    end
  end

  a_r3_freeze_on_trig: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPT && trig && !rearm) |=> (state == ST_DONE && trig_addr == $past(wp)));
  a_r3_frozen_ptr: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !rearm) |=> $stable(wp));
  a_r4_addr_held: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_DONE && state == ST_DONE) |-> $stable(trig_addr));
endmodule

// File: rtl/dcm_obs_capture.sv
`timescale 1ns/1ps
module dcm_obs_capture
  import diag_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          start,
  input  logic          rearm,
  input  logic [CW-1:0] div,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output cap_st_t       state,
  output logic          store
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp;
  logic [CW-1:0] dcnt;

  assign store = smp_valid && (state == ST_CAPT) && (dcnt == '0) && !rearm;

  always_ff @(posedge clk) begin
    if (store) mem[wp] <= smp_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || rearm) begin
      state <= ST_ARMED;
      wp    <= '0;
      dcnt  <= '0;
    end else begin
      case (state)
        ST_ARMED: if (start) begin
          state <= ST_CAPT;
          wp    <= '0;
          dcnt  <= '0;
        end
        ST_CAPT: if (smp_valid) begin
          dcnt <= (dcnt == div) ? '0 : dcnt + 1'b1;
          if (store) begin
            wp <= wp + 1'b1;
            if (&wp) state <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  a_r6_armed_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED) |-> !store);
  a_r7_div_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPT && $past(state) == ST_CAPT && $stable(div)) |-> (dcnt <= div));
  a_r8_done_stays: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !rearm) |=> (state == ST_DONE));
endmodule

// File: rtl/dcm_exc_player.sv
`timescale 1ns/1ps
module dcm_exc_player #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          obs_cap,
  input  logic          adv,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [DW-1:0] tbl_data,
  output logic [DW-1:0] exc_data,
  output logic          exc_valid
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] tbl [DEPTH];
  logic [AW-1:0] ptr;
  logic          run;

  always_ff @(posedge clk) begin
    if (tbl_we) tbl[tbl_addr] <= tbl_data;
  end

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      run <= 1'b0;
      ptr <= '0;
    end else if (start) begin
      run <= 1'b1;
      ptr <= '0;
    end else if (run && !obs_cap) begin
      run <= 1'b0;
    end else if (run && adv) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_data  <= '0;
      exc_valid <= 1'b0;
    end else begin
      exc_valid <= run && obs_cap;
      exc_data  <= (run && obs_cap) ? tbl[ptr] : '0;
    end
  end

  a_r10_valid_needs_capture: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> $past(obs_cap));
  a_r10_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
    !exc_valid |-> (exc_data == '0));
endmodule

// File: rtl/diag_capture_mem.sv
`timescale 1ns/1ps
module diag_capture_mem
  import diag_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          pm_trig_n,
  input  logic          obs_trig_n,
  input  logic          ana_trig_n,
  input  logic          bus_wr,
  input  logic [AW+1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] exc_data,
  output logic          exc_valid
);
  logic [1:0]    rgn;
  logic [AW-1:0] off;
  assign rgn = bus_addr[AW+1:AW];
  assign off = bus_addr[AW-1:0];

  logic pm_prev, obs_prev, ana_prev;
  logic pm_evt, obs_evt, ana_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_prev  <= 1'b1;
      obs_prev <= 1'b1;
      ana_prev <= 1'b1;
    end else begin
      pm_prev  <= pm_trig_n;
      obs_prev <= obs_trig_n;
      ana_prev <= ana_trig_n;
    end
  end

  assign pm_evt  = pm_prev  && !pm_trig_n;
  assign obs_evt = obs_prev && !obs_trig_n;
  assign ana_evt = ana_prev && !ana_trig_n;

  logic ctl_wr, rearm_pm, rearm_obs, tbl_we;
  assign ctl_wr    = bus_wr && (rgn == RGN_CTRL);
  assign rearm_pm  = ctl_wr && (off == AW'(0)) && bus_wdata[0];
  assign rearm_obs = ctl_wr && (off == AW'(0)) && bus_wdata[1];
  assign tbl_we    = bus_wr && (rgn == RGN_EXC);

  logic [CW-1:0] div_q;
  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else if (ctl_wr && off == AW'(1)) div_q <= bus_wdata[CW-1:0];
  end

  cap_st_t       pm_st, obs_st;
  logic [AW-1:0] pm_taddr;
  logic [DW-1:0] pm_rd, obs_rd;
  logic          obs_store, ana_start;

  assign ana_start = ana_evt && (obs_st == ST_ARMED) && !rearm_obs;

  dcm_pm_ring #(.DW(DW), .AW(AW)) u_ring (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .trig(pm_evt), .rearm(rearm_pm), .rd_addr(off), .rd_data(pm_rd),
    .state(pm_st), .trig_addr(pm_taddr)
  );

  dcm_obs_capture #(.DW(DW), .AW(AW), .CW(CW)) u_snap (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .start(obs_evt || ana_evt), .rearm(rearm_obs), .div(div_q),
    .rd_addr(off), .rd_data(obs_rd), .state(obs_st), .store(obs_store)
  );

  dcm_exc_player #(.DW(DW), .AW(AW)) u_exc (
    .clk(clk), .rst(rst), .start(ana_start), .stop(rearm_obs),
    .obs_cap(obs_st == ST_CAPT), .adv(obs_store),
    .tbl_we(tbl_we), .tbl_addr(off), .tbl_data(bus_wdata),
    .exc_data(exc_data), .exc_valid(exc_valid)
  );

  logic [DW-1:0] ctl_q;
  logic [1:0]    rgn_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      rgn_q <= RGN_CTRL;
    end else begin
      rgn_q <= rgn;
      if (off == AW'(0))      ctl_q <= DW'({obs_st, pm_st});
      else if (off == AW'(1)) ctl_q <= DW'(div_q);
      else if (off == AW'(2)) ctl_q <= DW'(pm_taddr);
      else                    ctl_q <= '0;
    end
  end

  always_comb begin
    case (rgn_q)
      RGN_CTRL: bus_rdata = ctl_q;
      RGN_RING: bus_rdata = pm_rd;
      RGN_SNAP: bus_rdata = obs_rd;
      default:  bus_rdata = '0;
    endcase
  end

  a_r9_same_edge: assert property (@(posedge clk) disable iff (rst)
    ana_start |=> (obs_st == ST_CAPT));
  a_r11_no_play_unarmed: assert property (@(posedge clk) disable iff (rst)
    (ana_evt && obs_st != ST_ARMED && !exc_valid && !rearm_obs) |=> !exc_valid);
  a_r5_rearm_ring: assert property (@(posedge clk) disable iff (rst)
    rearm_pm |=> (pm_st == ST_CAPT));
endmodule

// File: tb/tb_diag_capture_mem.sv
`timescale 1ns/1ps
module tb_diag_capture_mem;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic pm_trig_n = 1'b1, obs_trig_n = 1'b1, ana_trig_n = 1'b1;
  logic bus_wr = 1'b0;
  logic [AW+1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata, exc_data;
  logic exc_valid;

  int total = 0;
  int bad = 0;
  int seq = 100;
  bit finished = 0;

  always #5 clk = ~clk;

  diag_capture_mem #(.DW(DW), .AW(AW), .CW(16)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .pm_trig_n(pm_trig_n), .obs_trig_n(obs_trig_n), .ana_trig_n(ana_trig_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .exc_data(exc_data), .exc_valid(exc_valid)
  );

  localparam logic [15:0] DIV_TAB [4] = '{16'd0, 16'd1, 16'd2, 16'd4};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'b1;
      smp_data = DW'(seq);
      seq++;
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] r, input int o, input logic [DW-1:0] d);
    bus_wr = 1'b1;
    bus_addr = {r, AW'(o)};
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] r, input int o, output logic [DW-1:0] d);
    bus_addr = {r, AW'(o)};
    @(posedge clk);
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic pulse(input int which);
    if (which == 0) pm_trig_n = 1'b0;
    else if (which == 1) obs_trig_n = 1'b0;
    else ana_trig_n = 1'b0;
    @(negedge clk);
    pm_trig_n = 1'b1; obs_trig_n = 1'b1; ana_trig_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, 0, v);
    chk("R1 status", v, 32'h6);
    chk("R1 exc_valid", exc_valid, 0);
    chk("R1 exc_data", exc_data, 0);

    // R2/R3 ring wrap and freeze
    push(40);
    pulse(0);
    push(5);
    rd(2'd0, 0, v);
    chk("R3 ring done", v & 16'h3, 32'h3);
    chk("R6 snap armed quiet", (v >> 2) & 16'h3, 32'h1);
    rd(2'd0, 2, v);
    chk("R3 trig addr", v, 32'd8);
    for (int i = 0; i < DEPTH; i++) begin
      rd(2'd1, (8 + i) % DEPTH, v);
      chk("R2 ring chrono", v, 32'(124 + i));
    end

    // R4 second trigger ignored
    pulse(0);
    push(3);
    rd(2'd0, 2, v);
    chk("R4 addr held", v, 32'd8);
    rd(2'd1, 8, v);
    chk("R4 content held", v, 32'd124);

    // R5 rearm ring
    wr(2'd0, 0, 16'h1);
    rd(2'd0, 0, v);
    chk("R5 ring rearmed", v & 16'h3, 32'h2);

    // R7/R8 decimation table
    for (int t = 0; t < 4; t++) begin
      wr(2'd0, 1, DIV_TAB[t]);
      wr(2'd0, 0, 16'h2);
      push(3);
      rd(2'd0, 0, v);
      chk("R6 armed before trig", (v >> 2) & 16'h3, 32'h1);
      pulse(1);
      base = seq;
      push(DEPTH * (int'(DIV_TAB[t]) + 1) + 3);
      rd(2'd0, 0, v);
      chk("R8 snap done", (v >> 2) & 16'h3, 32'h3);
      for (int i = 0; i < DEPTH; i++) begin
        rd(2'd2, i, v);
        chk("R7 decimated sample", v, 32'(DW'(base + i * (int'(DIV_TAB[t]) + 1))));
      end
    end

    // R7/R12 divider max readback
    wr(2'd0, 1, 16'hFFFF);
    rd(2'd0, 1, v);
    chk("R7 div max", v, 32'hFFFF);

    // R9 analyze: table load then synchronized play
    for (int i = 0; i < DEPTH; i++) wr(2'd3, i, 16'h5000 + 16'(i * 37));
    wr(2'd0, 1, 16'h0);
    wr(2'd0, 0, 16'h2);
    pulse(2);
    rd(2'd0, 0, v);
    chk("R9 snap capturing", (v >> 2) & 16'h3, 32'h2);
    chk("R9 exc_valid on", exc_valid, 1);
    base = seq;
    for (int k = 0; k < DEPTH; k++) begin
      smp_valid = 1'b1;
      smp_data = DW'(seq);
      seq++;
      @(posedge clk);
      #1;
      chk("R9 exc entry", exc_data, 32'(16'h5000 + 16'(k * 37)));
      chk("R9 exc_valid", exc_valid, 1);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R10 exc_valid off", exc_valid, 0);
    chk("R10 exc_data zero", exc_data, 0);
    @(negedge clk);
    rd(2'd2, 0, v);
    chk("R9 aligned first", v, 32'(DW'(base)));
    rd(2'd2, DEPTH - 1, v);
    chk("R9 aligned last", v, 32'(DW'(base + DEPTH - 1)));

    // R11 analyze while done
    pulse(2);
    @(posedge clk);
    #1 chk("R11 no play", exc_valid, 0);
    @(negedge clk);
    rd(2'd0, 0, v);
    chk("R11 snap still done", (v >> 2) & 16'h3, 32'h3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule